// File: doc/BRIEF.md
# Three-Phase Overlapping Charge-Transfer Clock Generator

This block drives the three gate phases of one charge-coupled shift register. While idle it holds the integration bias: phases 1 and 2 high and phase 3 low, so that phase 3 acts as the barrier between neighbouring charge packets. Each shift request runs one full transfer cycle. The cycle first gathers the packet under phase 1, then walks it from phase 1 to phase 2, from phase 2 to phase 3, and from phase 3 onto the phase 1 of the next cell. The cycle then restores the integration bias. One cycle therefore moves the register by exactly one pixel or one row.

Each hand-over from one phase to the next is make-before-break. The receiving phase rises first, both phases stay high for a programmable overlap, and only then does the giving phase fall. The settled single-phase steps last for a programmable dwell. A design can use one instance for the row register and one for the column register. The outputs are digital phase enables and a one-cycle completion pulse. Level shifting and slew shaping are done outside the block.

Top module: `ccd3_phase_gen`

## Requirements
- R1: After reset, and whenever no cycle is running, `phase_o` is 3'b011 and `done_o` is low. Bit 0 is phase 1, bit 1 is phase 2 and bit 2 is phase 3.
- R2: A request sampled high at an idle clock edge makes `phase_o` equal 3'b001 in the next cycle. Only phase 1 is then high, so the charge collects under it.
- R3: A cycle steps through the patterns 001, 011, 010, 110, 100, 101 and 001 in that order, and then returns to 011.
- R4: The single-phase steps (001, 010, 100 and the final 001) each last D cycles. The two-phase overlap steps (011, 110, 101) each last O cycles. D is `dwell_cyc`, O is `ovl_cyc`, and a value of 0 is treated as 1.
- R5: A cycle lasts 4D+3O clocks. `done_o` is high for exactly one cycle, and that cycle is the first one in which 3'b011 is restored.
- R6: One or two phases are high in every cycle, never zero and never three. At most one phase changes between consecutive cycles.
- R7: Requests that arrive while a cycle runs are merged into a single pending shift. That shift starts right after the done cycle, so 3'b011 is shown for exactly one cycle between the two shifts.
- R8: `dwell_cyc` and `ovl_cyc` are captured when a cycle starts. Changing them during the cycle does not change its timing.
- R9: A reset during a cycle restores 3'b011, keeps `done_o` low and discards any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_req | input | 1 | Request for one single-cell shift |
| dwell_cyc | input | CW | Dwell length of the settled steps, in clocks (0 is treated as 1) |
| ovl_cyc | input | CW | Overlap length of the two-high steps, in clocks (0 is treated as 1) |
| phase_o | output | 3 | Phase enables; bit 0 is phase 1 |
| done_o | output | 1 | One-cycle pulse when a transfer cycle has finished |

## Verification
The bench traces the phases cycle by cycle for a table of dwell and overlap pairs. Unequal pairs such as (2,1) and (1,3) tell a swapped dwell and overlap counter apart from a correct one. Equal pairs isolate the ordering of the patterns. The pair (0,0) shows whether zero is clamped to one. Directed runs cover three further cases: a burst of requests during a cycle, which must yield exactly one follow-on shift; inputs changed mid-cycle, which must leave the timing alone; and a reset during a cycle, which must return the block to the integration bias and drop the pending shift.

// File: rtl/ccd3_pkg.sv
// Shared types for the three-phase clock generator.
// Assumes phase bit 0 is phase 1, bit 1 is phase 2, bit 2 is phase 3.
package ccd3_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_OV12,
        ST_HOLD2,
        ST_OV23,
        ST_HOLD3,
        ST_OV31,
        ST_HOLD1
    } step_e;

    localparam logic [2:0] PAT_INTEG = 3'b011;

    // Successor of each step in one transfer cycle.
    function automatic step_e step_next(step_e s);
        case (s)
            ST_COLLECT: return ST_OV12;
            ST_OV12:    return ST_HOLD2;
            ST_HOLD2:   return ST_OV23;
            ST_OV23:    return ST_HOLD3;
            ST_HOLD3:   return ST_OV31;
            ST_OV31:    return ST_HOLD1;
            default:    return ST_IDLE;
        endcase
    endfunction

    // True for steps in which two adjacent phases are both high.
    function automatic logic step_is_overlap(step_e s);
        return (s == ST_OV12) || (s == ST_OV23) || (s == ST_OV31);
    endfunction

endpackage

// File: rtl/ccd3_step_timer.sv
// Down-counter that times one step of the transfer cycle.
// A load of value v makes expire_o high on the v-th cycle after the load.
// A load of 0 behaves like a load of 1.
module ccd3_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    // Counter: reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= (load_val_i == '0) ? '0 : load_val_i - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag: this is the last cycle of the current step.
    always_comb expire_o = (cnt_q == '0);

endmodule

// File: rtl/ccd3_phase_map.sv
// Maps a step of the transfer cycle to the three phase enables.
// Purely combinational. Each step differs from its neighbours in one bit.
module ccd3_phase_map
    import ccd3_pkg::*;
(
    input  step_e       step_i,
    output logic [2:0]  phase_o
);
    // Decode: settled steps have one phase high, overlap steps have two.
    always_comb begin
        case (step_i)
            ST_COLLECT: phase_o = 3'b001;
            ST_OV12:    phase_o = 3'b011;
            ST_HOLD2:   phase_o = 3'b010;
            ST_OV23:    phase_o = 3'b110;
            ST_HOLD3:   phase_o = 3'b100;
            ST_OV31:    phase_o = 3'b101;
            ST_HOLD1:   phase_o = 3'b001;
            default:    phase_o = PAT_INTEG;
        endcase
    end

endmodule

// File: rtl/ccd3_phase_gen.sv
// Three-phase overlapping clock generator for one charge-coupled register.
// Idle holds the integration bias. Each request runs one make-before-break
// transfer cycle of 4*dwell + 3*overlap clocks and ends with a done pulse.
// Assumes dwell and overlap are stable at the start edge. They are captured
// there, so later changes have no effect on the running cycle.
module ccd3_phase_gen
    import ccd3_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_req,
    input  logic [CW-1:0] dwell_cyc,
    input  logic [CW-1:0] ovl_cyc,
    output logic [2:0]    phase_o,
    output logic          done_o
);
    step_e         step_q;
    step_e         step_nx;
    logic          pend_q;
    logic          done_q;
    logic [CW-1:0] dwell_q;
    logic [CW-1:0] ovl_q;
    logic          go;
    logic          adv;
    logic          expire;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;

    // Start/advance decisions and the length of the next step.
    always_comb begin
        step_nx  = step_next(step_q);
        go       = (step_q == ST_IDLE) && (shift_req || pend_q);
        adv      = (step_q != ST_IDLE) && expire;
        tmr_load = go || (adv && step_nx != ST_IDLE);
        if (go)
            tmr_val = dwell_cyc;
        else if (step_is_overlap(step_nx))
            tmr_val = ovl_q;
        else
            tmr_val = dwell_q;
    end

    // Step sequencer with capture of the timing settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_IDLE;
            dwell_q <= '0;
            ovl_q   <= '0;
        end else if (go) begin
            step_q  <= ST_COLLECT;
            dwell_q <= dwell_cyc;
            ovl_q   <= ovl_cyc;
        end else if (adv) begin
            step_q  <= step_nx;
        end
    end

    // Pending request: set by a request during a cycle, cleared at start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (go)
            pend_q <= 1'b0;
        else if (step_q != ST_IDLE && shift_req)
            pend_q <= 1'b1;
    end

    // Done pulse: high in the first idle cycle after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= adv && (step_nx == ST_IDLE);
    end

    always_comb done_o = done_q;

    ccd3_step_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (expire)
    );

    ccd3_phase_map u_map (
        .step_i  (step_q),
        .phase_o (phase_o)
    );

endmodule

// File: rtl/ccd3_phase_gen_chk.sv
// Checker for the phase generator. It watches only the top-level ports.
module ccd3_phase_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase_o,
    input logic       done_o
);
    // At least one barrier and at least one collecting phase in every cycle.
    assert_barrier_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(phase_o) == 1) || ($countones(phase_o) == 2));

    // Make-before-break: never two phases switching in the same clock.
    assert_one_edge_per_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_o ^ $past(phase_o)) <= 1);

    // Done lasts exactly one cycle.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Done coincides with the restored integration bias.
    assert_done_integ_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (phase_o == 3'b011));

    // After done, either stay idle or start a held request with phase 1 alone.
    assert_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (phase_o == 3'b011 || phase_o == 3'b001));

endmodule

bind ccd3_phase_gen ccd3_phase_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_o (phase_o),
    .done_o  (done_o)
);

// File: tb/ccd3_phase_gen_tb.sv
`timescale 1ns/1ps
module ccd3_phase_gen_tb;
    localparam int CW = 8;
    localparam int NV = 6;
    localparam int VEC_D [NV] = '{1, 2, 1, 3, 0, 4};
    localparam int VEC_O [NV] = '{1, 1, 3, 2, 0, 4};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_req = 1'b0;
    logic [CW-1:0] dwell_cyc = '0;
    logic [CW-1:0] ovl_cyc = '0;
    logic [2:0]    phase_o;
    logic          done_o;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    ccd3_phase_gen #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_req(shift_req),
        .dwell_cyc(dwell_cyc), .ovl_cyc(ovl_cyc),
        .phase_o(phase_o), .done_o(done_o)
    );

    // Expected phases at cycle i of a run, from R3/R4.
    function automatic logic [2:0] exp_ph(int i, int d, int o);
        int de = (d < 1) ? 1 : d;
        int oe = (o < 1) ? 1 : o;
        int acc = 0;
        logic [2:0] pats [7] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101, 3'b001};
        for (int s = 0; s < 7; s++) begin
            acc += (s % 2 == 1) ? oe : de;
            if (i < acc) return pats[s];
        end
        return 3'b011;
    endfunction

    function automatic int run_len(int d, int o);
        return 4 * ((d < 1) ? 1 : d) + 3 * ((o < 1) ? 1 : o);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Raise a request at a negedge with the given settings. Return at the
    // negedge after the start edge, which is cycle 0 of the run.
    task automatic start_req(input int d, input int o);
        dwell_cyc = CW'(d);
        ovl_cyc   = CW'(o);
        shift_req = 1'b1;
        @(negedge clk);
        shift_req = 1'b0;
    endtask

    // Trace one run from cycle 0. Optionally hold req high in cycles 1..3.
    // Returns at the done cycle after checking it.
    task automatic run_trace(input int d, input int o, input bit burst);
        int bad = 0, bad6 = 0, first_i = -1;
        logic [2:0] act_first = 3'b000, exp_first = 3'b000;
        logic [2:0] prev = 3'b011;
        int n = run_len(d, o);
        for (int i = 0; i < n; i++) begin
            if (burst) shift_req = (i >= 1 && i <= 3);
            if (phase_o !== exp_ph(i, d, o) || done_o !== 1'b0) begin
                if (first_i < 0) begin
                    first_i = i; act_first = phase_o; exp_first = exp_ph(i, d, o);
                end
                bad++;
            end
            if (!($countones(phase_o) inside {1, 2}) || $countones(phase_o ^ prev) > 1) bad6++;
            prev = phase_o;
            @(negedge clk);
        end
        shift_req = 1'b0;
        chk(bad == 0, $sformatf("R2 R3 R4 trace d=%0d o=%0d at cycle %0d", d, o, first_i),
            int'(act_first), int'(exp_first));
        chk(bad6 == 0, "R6 barrier/single-edge", bad6, 0);
        chk(phase_o == 3'b011 && done_o == 1'b1, "R5 done at 4D+3O with integ pattern",
            int'({done_o, phase_o}), int'({1'b1, 3'b011}));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(phase_o == 3'b011 && done_o == 1'b0, "R1 reset state", int'({done_o, phase_o}), 3);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(phase_o == 3'b011 && done_o == 1'b0, "R1 idle pattern", int'({done_o, phase_o}), 3);

        // Table of dwell/overlap pairs.
        for (int v = 0; v < NV; v++) begin
            start_req(VEC_D[v], VEC_O[v]);
            run_trace(VEC_D[v], VEC_O[v], 1'b0);
            @(negedge clk);
            chk(done_o == 1'b0 && phase_o == 3'b011, "R5 done one cycle, R1 idle after",
                int'({done_o, phase_o}), 3);
            @(negedge clk);
        end

        // R7: burst of requests during a run gives exactly one follow-on shift.
        start_req(2, 1);
        run_trace(2, 1, 1'b1);
        @(negedge clk);
        chk(phase_o == 3'b001, "R7 pending shift starts after done", int'(phase_o), 1);
        run_trace(2, 1, 1'b0);
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (phase_o != 3'b011 || done_o) extra++;
            end
            chk(extra == 0, "R7 burst collapsed to one pending shift", extra, 0);
        end

        // R8: changing settings mid-cycle does not alter timing.
        start_req(2, 1);
        dwell_cyc = 8'd5;
        ovl_cyc   = 8'd5;
        run_trace(2, 1, 1'b0);
        repeat (2) @(negedge clk);

        // R9: reset mid-cycle with a pending request.
        start_req(3, 3);
        shift_req = 1'b1;
        repeat (4) @(negedge clk);
        shift_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(phase_o == 3'b011 && done_o == 1'b0, "R9 reset mid-cycle restores integ",
            int'({done_o, phase_o}), 3);
        rst_n = 1'b1;
        begin
            int moved = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (phase_o != 3'b011 || done_o) moved++;
            end
            chk(moved == 0, "R9 pending request dropped by reset", moved, 0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule